// File: doc/BRIEF.md
# Cascadable Four-Channel Timer Bank

The block contains four 16-bit up-counters, each with a reload value and a control word. A counter either steps once per prescaled period of the input clock, or, in chained mode, steps each time the counter one index below it wraps. On a wrap the counter restarts from its reload value, and if its interrupt-enable bit is set it pulses its own interrupt line for one clock.

Software reaches the timers through a synchronous register bus. The bus takes a byte address, a write strobe and a width select, and returns read data combinationally. Each timer has a four-byte slot. A 16-bit access reaches one halfword of the slot. A 32-bit access reaches the reload and the control word together. Setting the run bit preloads the counter. Clearing it freezes the counter.

Top module: `cascade_timer_bank`

## Requirements
- R1: A synchronous active-high `rst` clears every counter, reload value, control word, prescaler and interrupt output to zero.
- R2: Timer i owns byte addresses 4*i to 4*i+3, and address bit 0 is ignored. With `bus_wide`=0, bit 1 of the address selects the halfword. When bit 1 is 0, a write sets the reload value and a read returns the live counter in `bus_rdata[15:0]`. When bit 1 is 1, the full 16-bit control word is written and read back. Upper read bits are zero in both cases.
- R3: With `bus_wide`=1, a write sets the reload from `bus_wdata[15:0]` and applies `bus_wdata[31:16]` as a control write. A write that starts the timer preloads this new reload value. A read returns {control, counter}.
- R4: Control bits 1:0 select a step period of 2, 128, 512 or 2048 clocks for values 0 to 3. The prescaler restarts at each start, so the first step comes one full period after the starting write.
- R5: A control write that changes bit 7 (run) from 0 to 1 while bit 2 is 0 copies the reload value into the counter. A control write made while run is already 1 does not touch the counter.
- R6: A control write that clears run stops the timer. The counter keeps its value.
- R7: A step from 0xFFFF loads the reload value in place of 0. Writing the reload value while the timer runs leaves the counter unchanged until that load.
- R8: On a wrap with control bit 6 set, `irq[i]` is high for exactly one clock, in the clock after the wrap. With bit 6 clear, the wrap raises no interrupt.
- R9: Timer i+1 steps on each wrap of timer i only while its bits 7 and 2 are both 1. Wraps that ripple through the chain in one clock pulse all their enabled interrupt lines in the same clock.
- R10: Timer 0 with bit 2 set never steps. A start with bit 2 set does not preload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address within the bank |
| bus_wr | input | 1 | Write strobe, one access per clock |
| bus_wide | input | 1 | 1 selects a 32-bit access, 0 a 16-bit access |
| bus_wdata | input | 32 | Write data; 16-bit writes use bits 15:0 |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 4 | One interrupt pulse line per timer |

## Verification
The hardest case to reach is a chained wrap that ripples through two counters in one clock. The second counter must hold 0xFFFF at that moment, and a chained start never preloads. The stimulus therefore starts timer 1 in prescaled mode so that it picks up 0xFFFF. It stops the timer before its first step and then restarts it in chained mode. Timer 0 is then started at 0xFFFF, and the bench checks that the counters of timers 1 and 2 and two interrupt lines change together. The prescaler sweep covers every timer at every period setting, including the clock just before the first step.

// File: rtl/ctb_pkg.sv
`timescale 1ns/1ps
package ctb_pkg;
   // control word field positions
   localparam int CTL_PS_LO = 0;
   localparam int CTL_PS_HI = 1;
   localparam int CTL_CASC  = 2;
   localparam int CTL_IE    = 6;
   localparam int CTL_RUN   = 7;

   // prescaler count width, enough for the longest period
   localparam int PRE_W = 11;

   // terminal count for each prescaler selection (period minus one)
   function automatic logic [PRE_W-1:0] ps_limit(input logic [1:0] sel);
      case (sel)
         2'd0:    ps_limit = PRE_W'(1);
         2'd1:    ps_limit = PRE_W'(127);
         2'd2:    ps_limit = PRE_W'(511);
         default: ps_limit = PRE_W'(2047);
      endcase
   endfunction
endpackage

// File: rtl/ctb_prescaler.sv
`timescale 1ns/1ps
module ctb_prescaler
   import ctb_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       clear,
   input  logic       enable,
   input  logic [1:0] sel,
   output logic       tick
);
   logic [PRE_W-1:0] div_q;

   // >= keeps a shortened period from running to wrap
   assign tick = enable && (div_q >= ps_limit(sel));

   always_ff @(posedge clk) begin
      if (rst || clear)  div_q <= '0;
      else if (tick)     div_q <= '0;
      else if (enable)   div_q <= div_q + 1'b1;
   end
endmodule

// File: rtl/ctb_decode.sv
`timescale 1ns/1ps
module ctb_decode #(
   parameter int NUM_TIMERS = 4,
   parameter int CNT_W      = 16,
   parameter int ADDR_W     = 4
) (
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_wide,
   input  logic [2*CNT_W-1:0]   bus_wdata,
   output logic [NUM_TIMERS-1:0] wr_reload,
   output logic [NUM_TIMERS-1:0] wr_ctrl,
   output logic [CNT_W-1:0]     reload_wd,
   output logic [CNT_W-1:0]     ctrl_wd
);
   localparam int SLOT_W = ADDR_W - 2;

   logic [SLOT_W-1:0] slot;
   logic              upper;

   assign slot  = bus_addr[ADDR_W-1:2];
   assign upper = bus_addr[1];

   for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_slot
      logic hit;
      assign hit          = bus_wr && (slot == SLOT_W'(i));
      assign wr_reload[i] = hit && (bus_wide || !upper);
      assign wr_ctrl[i]   = hit && (bus_wide || upper);
   end

   assign reload_wd = bus_wdata[CNT_W-1:0];
   assign ctrl_wd   = bus_wide ? bus_wdata[2*CNT_W-1:CNT_W] : bus_wdata[CNT_W-1:0];
endmodule

// File: rtl/ctb_channel.sv
`timescale 1ns/1ps
module ctb_channel
   import ctb_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_reload,
   input  logic             wr_ctrl,
   input  logic [CNT_W-1:0] reload_wd,
   input  logic [CNT_W-1:0] ctrl_wd,
   input  logic             chain_in,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] ctrl_o,
   output logic             wrap_o,
   output logic             irq_o
);
   logic [CNT_W-1:0] reload_q, count_q, ctrl_q, reload_nx;
   logic             run, chained, start_edge, ptick, step, wraps, irq_q;

   assign run        = ctrl_q[CTL_RUN];
   assign chained    = ctrl_q[CTL_CASC];
   assign start_edge = wr_ctrl && !run && ctrl_wd[CTL_RUN];
   assign reload_nx  = wr_reload ? reload_wd : reload_q;

   ctb_prescaler u_pre (
      .clk    (clk),
      .rst    (rst),
      .clear  (start_edge),
      .enable (run && !chained),
      .sel    (ctrl_q[CTL_PS_HI:CTL_PS_LO]),
      .tick   (ptick)
   );

   assign step  = run && (chained ? chain_in : ptick);
   assign wraps = step && (count_q == '1);

   always_ff @(posedge clk) begin
      if (rst) begin
         reload_q <= '0;
         ctrl_q   <= '0;
         count_q  <= '0;
         irq_q    <= 1'b0;
      end else begin
         if (wr_reload) reload_q <= reload_wd;
         if (wr_ctrl)   ctrl_q   <= ctrl_wd;
         if (start_edge && !ctrl_wd[CTL_CASC]) count_q <= reload_nx;
         else if (wraps)                       count_q <= reload_q;
         else if (step)                        count_q <= count_q + 1'b1;
         irq_q <= wraps && ctrl_q[CTL_IE];
      end
   end

   assign count_o = count_q;
   assign ctrl_o  = ctrl_q;
   assign wrap_o  = wraps;
   assign irq_o   = irq_q;
endmodule

// File: rtl/cascade_timer_bank.sv
`timescale 1ns/1ps
module cascade_timer_bank
   import ctb_pkg::*;
#(
   parameter int NUM_TIMERS = 4,
   parameter int CNT_W      = 16,
   parameter int ADDR_W     = $clog2(NUM_TIMERS) + 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_wr,
   input  logic                  bus_wide,
   input  logic [2*CNT_W-1:0]    bus_wdata,
   output logic [2*CNT_W-1:0]    bus_rdata,
   output logic [NUM_TIMERS-1:0] irq
);
   localparam int SLOT_W = ADDR_W - 2;

   if (NUM_TIMERS < 2) begin : g_bad_count
      $error("cascade_timer_bank: NUM_TIMERS must be at least 2");
   end
   if (CNT_W < CTL_RUN + 1) begin : g_bad_width
      $error("cascade_timer_bank: CNT_W too narrow for control fields");
   end
   if (ADDR_W != $clog2(NUM_TIMERS) + 2) begin : g_bad_addr
      $error("cascade_timer_bank: ADDR_W must match NUM_TIMERS");
   end

   logic [NUM_TIMERS-1:0]            wr_reload, wr_ctrl, wrap, chain_in;
   logic [CNT_W-1:0]                 reload_wd, ctrl_wd;
   logic [NUM_TIMERS-1:0][CNT_W-1:0] ch_count, ch_ctrl;
   logic                             unused_addr_lsb;

   assign unused_addr_lsb = bus_addr[0];

   ctb_decode #(
      .NUM_TIMERS (NUM_TIMERS),
      .CNT_W      (CNT_W),
      .ADDR_W     (ADDR_W)
   ) u_dec (
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wide  (bus_wide),
      .bus_wdata (bus_wdata),
      .wr_reload (wr_reload),
      .wr_ctrl   (wr_ctrl),
      .reload_wd (reload_wd),
      .ctrl_wd   (ctrl_wd)
   );

   for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_ch
      // the lowest timer has no neighbour to chain from
      if (i == 0) begin : g_head
         assign chain_in[i] = 1'b0;
      end else begin : g_link
         assign chain_in[i] = wrap[i-1];
      end

      ctb_channel #(.CNT_W(CNT_W)) u_ch (
         .clk       (clk),
         .rst       (rst),
         .wr_reload (wr_reload[i]),
         .wr_ctrl   (wr_ctrl[i]),
         .reload_wd (reload_wd),
         .ctrl_wd   (ctrl_wd),
         .chain_in  (chain_in[i]),
         .count_o   (ch_count[i]),
         .ctrl_o    (ch_ctrl[i]),
         .wrap_o    (wrap[i]),
         .irq_o     (irq[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_TIMERS; i++) begin
         if (bus_addr[ADDR_W-1:2] == SLOT_W'(i)) begin
            if (bus_wide)         bus_rdata = {ch_ctrl[i], ch_count[i]};
            else if (bus_addr[1]) bus_rdata = {{CNT_W{1'b0}}, ch_ctrl[i]};
            else                  bus_rdata = {{CNT_W{1'b0}}, ch_count[i]};
         end
      end
   end
endmodule

// File: rtl/ctb_checker.sv
`timescale 1ns/1ps
module ctb_checker
   import ctb_pkg::*;
#(
   parameter int NUM_TIMERS = 4,
   parameter int CNT_W      = 16
) (
   input logic                             clk,
   input logic                             rst,
   input logic                             bus_wr,
   input logic [NUM_TIMERS-1:0]            irq,
   input logic [NUM_TIMERS-1:0][CNT_W-1:0] ch_count,
   input logic [NUM_TIMERS-1:0][CNT_W-1:0] ch_ctrl
);
   logic unused_ctrl_bits;
   assign unused_ctrl_bits = ^ch_ctrl;

   for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_prop
      // R8: interrupt is a one-clock pulse
      a_r8_irq_single: assert property (@(posedge clk) disable iff (rst)
         irq[i] |=> !irq[i]);

      // R8: a pulse only follows a clock in which interrupt enable was set
      a_r8_irq_needs_ie: assert property (@(posedge clk) disable iff (rst)
         irq[i] |-> $past(ch_ctrl[i][CTL_IE]));

      // R6: a stopped timer with no bus write keeps its counter
      a_r6_stopped_holds: assert property (@(posedge clk) disable iff (rst)
         (!ch_ctrl[i][CTL_RUN] && !bus_wr) |=> $stable(ch_count[i]));
   end

   // R10: timer 0 in chained mode never steps
   a_r10_head_chain_idle: assert property (@(posedge clk) disable iff (rst)
      (ch_ctrl[0][CTL_CASC] && !bus_wr) |=> $stable(ch_count[0]));
endmodule

bind cascade_timer_bank ctb_checker #(
   .NUM_TIMERS (NUM_TIMERS),
   .CNT_W      (CNT_W)
) u_ctb_checker (
   .clk      (clk),
   .rst      (rst),
   .bus_wr   (bus_wr),
   .irq      (irq),
   .ch_count (ch_count),
   .ch_ctrl  (ch_ctrl)
);

// File: tb/cascade_timer_bank_bench.sv
`timescale 1ns/1ps
module cascade_timer_bank_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic        wide = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  irq;
   int          total = 0;
   int          bad = 0;

   always #2.5 clk = ~clk;

   cascade_timer_bank u_cascade_timer_bank (
      .clk       (clk),
      .rst       (rst),
      .bus_addr  (addr),
      .bus_wr    (wr_en),
      .bus_wide  (wide),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .irq       (irq)
   );

   function automatic int period(input int s);
      return 1 << ((s == 0) ? 1 : 2 * s + 5);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int slot, input bit upper, input bit w, input logic [31:0] d);
      addr  = {slot[1:0], upper, 1'b0};
      wide  = w;
      wdata = d;
      wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int slot, input bit upper, input bit w, output logic [31:0] q);
      addr = {slot[1:0], upper, 1'b0};
      wide = w;
      #1;
      q = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      idle(3);
      rst = 1'b0;
   endtask

   initial begin
      logic [31:0] q;
      logic [15:0] rl;
      do_reset();

      // R1: everything zero after reset
      for (int t = 0; t < 4; t++) begin
         rd(t, 0, 1, q);
         chk("R1 reset slot", q, 32'h0);
      end
      chk("R1 reset irq", {28'b0, irq}, 32'h0);

      // R2: halfword map, control readback, reload does not reach stopped counter
      for (int t = 0; t < 4; t++) begin
         wr(t, 1, 0, 32'h0000_0F03);
         rd(t, 1, 0, q);
         chk("R2 control readback", q, 32'h0000_0F03);
         wr(t, 0, 0, 32'h0000_1234);
         rd(t, 0, 0, q);
         chk("R2 counter untouched by reload write", q, 32'h0);
         wr(t, 1, 0, 32'h0);
      end

      // R4 R5 R6: sweep every timer at every prescaler setting
      for (int t = 0; t < 4; t++) begin
         for (int s = 0; s < 4; s++) begin
            int p;
            p  = period(s);
            rl = 16'h1000 + 16'(t * 16 + s);
            wr(t, 0, 0, {16'h0, rl});
            wr(t, 1, 0, 32'h80 | s);
            rd(t, 0, 0, q);
            chk("R5 start preloads", q, {16'h0, rl});
            idle(p - 1);
            rd(t, 0, 0, q);
            chk("R4 no step before one period", q, {16'h0, rl});
            idle(1);
            rd(t, 0, 0, q);
            chk("R4 first step", q, {16'h0, rl + 16'd1});
            idle(p);
            rd(t, 0, 0, q);
            chk("R4 second step", q, {16'h0, rl + 16'd2});
            wr(t, 1, 0, s);
            idle(5);
            rd(t, 0, 0, q);
            chk("R6 stopped counter holds", q, {16'h0, rl + 16'd2});
         end
      end

      // R3 R5: 32-bit write and read, no reload on rewrite while running
      wr(2, 0, 1, 32'h0080_ABCD);
      rd(2, 0, 1, q);
      chk("R3 wide read after wide write", q, 32'h0080_ABCD);
      idle(4);
      rd(2, 0, 0, q);
      chk("R4 two steps at period 2", q, 32'h0000_ABCF);
      wr(2, 1, 0, 32'h0000_0081);
      rd(2, 0, 0, q);
      chk("R5 rewrite while running keeps counter", q, 32'h0000_ABCF);
      wr(2, 1, 0, 32'h0);
      wr(2, 0, 1, 32'h0080_0100);
      rd(2, 0, 0, q);
      chk("R3 start preloads new reload", q, 32'h0000_0100);
      wr(2, 1, 0, 32'h0);

      // R7 R8: wrap reloads, reload write deferred, one-clock pulse
      wr(1, 0, 0, 32'h0000_FFFE);
      wr(1, 1, 0, 32'h0000_00C0);
      wr(1, 0, 0, 32'h0000_0500);
      rd(1, 0, 0, q);
      chk("R7 reload write leaves counter", q, 32'h0000_FFFE);
      idle(1);
      rd(1, 0, 0, q);
      chk("R7 count to top", q, 32'h0000_FFFF);
      idle(1);
      chk("R8 no pulse before wrap", {28'b0, irq}, 32'h0);
      idle(1);
      rd(1, 0, 0, q);
      chk("R7 wrap loads reload", q, 32'h0000_0500);
      chk("R8 pulse on wrap", {28'b0, irq}, 32'h2);
      idle(1);
      chk("R8 pulse lasts one clock", {28'b0, irq}, 32'h0);
      wr(1, 1, 0, 32'h0);

      // R8: wraps with interrupt enable clear stay silent
      wr(3, 0, 0, 32'h0000_FFFF);
      wr(3, 1, 0, 32'h0000_0080);
      for (int k = 0; k < 6; k++) begin
         idle(1);
         chk("R8 no pulse without enable", {28'b0, irq}, 32'h0);
      end
      wr(3, 1, 0, 32'h0);

      // R1 again after activity
      do_reset();
      rd(1, 0, 1, q);
      chk("R1 reset after activity", q, 32'h0);

      // R9 R10: prime timer 1 at 0xFFFF then chain it
      wr(1, 0, 0, 32'h0000_FFFF);
      wr(1, 1, 0, 32'h0000_0080);
      wr(1, 1, 0, 32'h0000_0000);
      rd(1, 0, 0, q);
      chk("R6 stop before first step", q, 32'h0000_FFFF);
      wr(1, 1, 0, 32'h0000_00C4);
      rd(1, 0, 0, q);
      chk("R10 chained start keeps counter", q, 32'h0000_FFFF);
      wr(2, 1, 0, 32'h0000_0084);
      wr(3, 1, 0, 32'h0000_0044);
      wr(0, 0, 0, 32'h0000_FFFF);
      wr(0, 1, 0, 32'h0000_00C0);
      idle(1);
      chk("R9 no pulse yet", {28'b0, irq}, 32'h0);
      idle(1);
      chk("R9 simultaneous pulses", {28'b0, irq}, 32'h3);
      rd(1, 0, 0, q);
      chk("R9 chained wrap reloads", q, 32'h0000_FFFF);
      rd(2, 0, 0, q);
      chk("R9 second link steps", q, 32'h0000_0001);
      rd(3, 0, 0, q);
      chk("R9 link without run stays", q, 32'h0);
      idle(1);
      chk("R9 pulses end", {28'b0, irq}, 32'h0);
      idle(1);
      chk("R9 pulses repeat", {28'b0, irq}, 32'h3);
      rd(2, 0, 0, q);
      chk("R9 second link steps again", q, 32'h0000_0002);
      wr(0, 1, 0, 32'h0);

      // R10: timer 0 with chained mode never moves
      do_reset();
      wr(0, 0, 0, 32'h0000_0010);
      wr(0, 1, 0, 32'h0000_0084);
      rd(0, 0, 0, q);
      chk("R10 head chained start no preload", q, 32'h0);
      idle(10);
      rd(0, 0, 0, q);
      chk("R10 head chained stays", q, 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_000_000;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule